// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block chooses which set of frequency settings a clock synthesizer uses. One source is a 5-bit strap value taken from the board at power-up. The others are a software select index, a programmed N/M pair and a recovery N/M pair. From these it produces the active ratio/gear index, the active N and M with a flag that says whether they are in use and legal, and a one-cycle event that tells the synthesizer to reload.

The register values arrive as write strobes with data, plus a marker for the end of each bus transaction. A watchdog timeout pulse forces the block into recovery. The block stays in recovery until reset, or until software clears the timeout status through a clear pulse.

The sources have a fixed priority:
- recovery from the recovery pair (highest),
- recovery from the strap value,
- the programmed pair,
- plain index selection (lowest).

The synthesizer computes gear × (N+3)/(M+3). Computing the gear constant from the index is left to the consumer.

Top module: `clk_src_sel`

## Requirements
- R1: While `rst_n` is low, `strap_o` follows `strap_i` on every clock edge. After release it holds the last value sampled before release and ignores later changes on `strap_i`.
- R2: Normal mode is neither recovery nor programmable (`mode_o` = 0). In it, `idx_o` equals the held strap value when `override_i` is 0 and `sw_sel_i` when it is 1. `n_o` and `m_o` read 0 and `nm_valid_o` is 0.
- R3: Programmed mode (`mode_o` = 1) applies when `prog_en_i` is 1 and the block is not in recovery. `n_o`/`m_o` show the last written programmed N/M register values, and `idx_o` is still chosen by `override_i` as in R2.
- R4: `nm_valid_o` is 1 exactly when an N/M pair is in use and (N+3) > (M+3).
- R5: `idx_valid_o` is 0 when `idx_o` is 10000, 10001 or 10010 (binary), and 1 for every other code.
- R6: A write to the programmed N or M register produces `freq_chg_o` = 1 in the cycle after the cycle in which `txn_end_i` closes that transaction.
- R7: A write to the recovery N or M register produces a change event in the same way as R6.
- R8: Several register writes within one transaction produce exactly one one-cycle event. No event is raised before `txn_end_i`.
- R9: A `wd_timeout_i` pulse puts the block into recovery from the next cycle. With `rcv_sel_i` = 0 (`mode_o` = 2), `idx_o` is the held strap value, `n_o`/`m_o` read 0 and `nm_valid_o` is 0.
- R10: In recovery with `rcv_sel_i` = 1 (`mode_o` = 3), `n_o`/`m_o` show the recovery N/M registers and `idx_o` is chosen by `override_i`.
- R11: Recovery persists until reset or a `wd_clr_i` pulse, which ends it from the next cycle. A timeout in the same cycle as a clear keeps the block in recovery.
- R12: Recovery outranks programmed mode: `prog_en_i` = 1 has no effect on the outputs while in recovery.
- R13: A transaction end with no register write produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; strap sampled while low |
| strap_i | input | 5 | Board strap index |
| sw_sel_i | input | 5 | Software select index |
| override_i | input | 1 | 0: strap index, 1: software index |
| prog_en_i | input | 1 | Enables programmed N/M |
| rcv_sel_i | input | 1 | Recovery source: 0 strap, 1 recovery pair |
| wr_pn_i | input | 1 | Write strobe, programmed N |
| pn_i | input | 8 | Programmed N data |
| wr_pm_i | input | 1 | Write strobe, programmed M |
| pm_i | input | 7 | Programmed M data |
| wr_rn_i | input | 1 | Write strobe, recovery N |
| rn_i | input | 8 | Recovery N data |
| wr_rm_i | input | 1 | Write strobe, recovery M |
| rm_i | input | 7 | Recovery M data |
| txn_end_i | input | 1 | Last cycle of a bus transaction |
| wd_timeout_i | input | 1 | Watchdog timeout pulse |
| wd_clr_i | input | 1 | Software clear of timeout status |
| strap_o | output | 5 | Held strap value |
| mode_o | output | 2 | Active source: 0 normal, 1 programmed, 2 recovery strap, 3 recovery pair |
| idx_o | output | 5 | Active ratio/gear index |
| idx_valid_o | output | 1 | Index is not a reserved code |
| n_o | output | 8 | Active N (0 when unused) |
| m_o | output | 7 | Active M (0 when unused) |
| nm_valid_o | output | 1 | N/M in use and legal |
| freq_chg_o | output | 1 | One-cycle frequency-change event |

## Verification
Some outputs follow level inputs (`override_i`, `sw_sel_i`, `prog_en_i`, `rcv_sel_i`) in the same cycle. Register writes, the recovery flag and the change event each settle one clock edge after their strobe. The bench drives every input on the falling edge and checks results on the next falling edge, so exactly one rising edge lies between stimulus and sample. Event checks also look one edge later to confirm that the pulse has dropped. Expected indices, pair legality and reserved codes are computed arithmetically from the sweep variables.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  typedef enum logic [1:0] {
    SRC_NORMAL    = 2'd0,
    SRC_PROG      = 2'd1,
    SRC_RCV_STRAP = 2'd2,
    SRC_RCV_PAIR  = 2'd3
  } src_e;
endpackage

// File: rtl/clk_src_strap.sv
module clk_src_strap #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] strap_i,
  output logic [IDX_W-1:0] strap_q
);
  // Transparent sampling throughout reset; frozen once reset is released.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end

  a_r1_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/clk_src_regs.sv
module clk_src_regs #(
  parameter int N_W = 8,
  parameter int M_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_pn_i,
  input  logic [N_W-1:0] pn_i,
  input  logic           wr_pm_i,
  input  logic [M_W-1:0] pm_i,
  input  logic           wr_rn_i,
  input  logic [N_W-1:0] rn_i,
  input  logic           wr_rm_i,
  input  logic [M_W-1:0] rm_i,
  input  logic           txn_end_i,
  output logic [N_W-1:0] pn_q,
  output logic [M_W-1:0] pm_q,
  output logic [N_W-1:0] rn_q,
  output logic [M_W-1:0] rm_q,
  output logic           chg_o
);
  logic wr_any;
  logic pend_q;

  assign wr_any = wr_pn_i | wr_pm_i | wr_rn_i | wr_rm_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pn_q <= '0;
      pm_q <= '0;
      rn_q <= '0;
      rm_q <= '0;
    end else begin
      if (wr_pn_i) pn_q <= pn_i;
      if (wr_pm_i) pm_q <= pm_i;
      if (wr_rn_i) rn_q <= rn_i;
      if (wr_rm_i) rm_q <= rm_i;
    end
  end

  // Writes are gathered until the transaction closes; one event per transaction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      chg_o  <= 1'b0;
    end else begin
      chg_o  <= txn_end_i & (pend_q | wr_any);
      pend_q <= txn_end_i ? 1'b0 : (pend_q | wr_any);
    end
  end

  a_r6_r7_event_due: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end_i && wr_any) |=> chg_o);
  a_r8_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> $past(txn_end_i));
  a_r13_no_write_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end_i && !wr_any && !pend_q) |=> !chg_o);
endmodule

// File: rtl/clk_src_arb.sv
module clk_src_arb
  import clk_src_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int OFS    = 3,
  parameter int RSV_LO = 16,
  parameter int RSV_HI = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_timeout_i,
  input  logic             wd_clr_i,
  input  logic             rcv_sel_i,
  input  logic             prog_en_i,
  input  logic             override_i,
  input  logic [IDX_W-1:0] strap_i,
  input  logic [IDX_W-1:0] sw_sel_i,
  input  logic [N_W-1:0]   pn_i,
  input  logic [M_W-1:0]   pm_i,
  input  logic [N_W-1:0]   rn_i,
  input  logic [M_W-1:0]   rm_i,
  output src_e             mode_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             idx_valid_o,
  output logic [N_W-1:0]   n_o,
  output logic [M_W-1:0]   m_o,
  output logic             nm_valid_o
);
  localparam int CW = N_W + 1;
  localparam logic [IDX_W-1:0] RSV_LO_V = RSV_LO[IDX_W-1:0];
  localparam logic [IDX_W-1:0] RSV_HI_V = RSV_HI[IDX_W-1:0];
  localparam logic [CW-1:0]    OFS_V    = OFS[CW-1:0];

  logic             rcv_q;
  logic [IDX_W-1:0] idx_sel;
  logic             pair_used;
  logic [CW-1:0]    n_ext, m_ext;

  // Timeout wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rcv_q <= 1'b0;
    else if (wd_timeout_i) rcv_q <= 1'b1;
    else if (wd_clr_i)     rcv_q <= 1'b0;
  end

  assign idx_sel = override_i ? sw_sel_i : strap_i;

  always_comb begin
    if (rcv_q) mode_o = rcv_sel_i ? SRC_RCV_PAIR : SRC_RCV_STRAP;
    else       mode_o = prog_en_i ? SRC_PROG : SRC_NORMAL;
  end

  always_comb begin
    idx_o     = idx_sel;
    n_o       = '0;
    m_o       = '0;
    pair_used = 1'b0;
    unique case (mode_o)
      SRC_NORMAL: ;
      SRC_PROG: begin
        n_o = pn_i; m_o = pm_i; pair_used = 1'b1;
      end
      SRC_RCV_STRAP: idx_o = strap_i;
      SRC_RCV_PAIR: begin
        n_o = rn_i; m_o = rm_i; pair_used = 1'b1;
      end
    endcase
  end

  assign n_ext       = CW'(n_o) + OFS_V;
  assign m_ext       = CW'(m_o) + OFS_V;
  assign nm_valid_o  = pair_used && (n_ext > m_ext);
  assign idx_valid_o = !((idx_o >= RSV_LO_V) && (idx_o <= RSV_HI_V));

  a_r9_enter_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout_i |=> (mode_o == SRC_RCV_STRAP || mode_o == SRC_RCV_PAIR));
  a_r11_stay_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_q && !wd_clr_i) |=> rcv_q);
  a_r11_leave_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_clr_i && !wd_timeout_i) |=> !rcv_q);
  a_r12_recovery_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_q |-> (mode_o != SRC_PROG));
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import clk_src_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int OFS    = 3,
  parameter int RSV_LO = 16,
  parameter int RSV_HI = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] strap_i,
  input  logic [IDX_W-1:0] sw_sel_i,
  input  logic             override_i,
  input  logic             prog_en_i,
  input  logic             rcv_sel_i,
  input  logic             wr_pn_i,
  input  logic [N_W-1:0]   pn_i,
  input  logic             wr_pm_i,
  input  logic [M_W-1:0]   pm_i,
  input  logic             wr_rn_i,
  input  logic [N_W-1:0]   rn_i,
  input  logic             wr_rm_i,
  input  logic [M_W-1:0]   rm_i,
  input  logic             txn_end_i,
  input  logic             wd_timeout_i,
  input  logic             wd_clr_i,
  output logic [IDX_W-1:0] strap_o,
  output logic [1:0]       mode_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             idx_valid_o,
  output logic [N_W-1:0]   n_o,
  output logic [M_W-1:0]   m_o,
  output logic             nm_valid_o,
  output logic             freq_chg_o
);
  logic [N_W-1:0] pn_q, rn_q;
  logic [M_W-1:0] pm_q, rm_q;
  src_e           mode;

  clk_src_strap #(.IDX_W(IDX_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .strap_q(strap_o)
  );

  clk_src_regs #(.N_W(N_W), .M_W(M_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_pn_i(wr_pn_i), .pn_i(pn_i), .wr_pm_i(wr_pm_i), .pm_i(pm_i),
    .wr_rn_i(wr_rn_i), .rn_i(rn_i), .wr_rm_i(wr_rm_i), .rm_i(rm_i),
    .txn_end_i(txn_end_i),
    .pn_q(pn_q), .pm_q(pm_q), .rn_q(rn_q), .rm_q(rm_q), .chg_o(freq_chg_o)
  );

  clk_src_arb #(.IDX_W(IDX_W), .N_W(N_W), .M_W(M_W), .OFS(OFS),
                .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .wd_timeout_i(wd_timeout_i), .wd_clr_i(wd_clr_i), .rcv_sel_i(rcv_sel_i),
    .prog_en_i(prog_en_i), .override_i(override_i),
    .strap_i(strap_o), .sw_sel_i(sw_sel_i),
    .pn_i(pn_q), .pm_i(pm_q), .rn_i(rn_q), .rm_i(rm_q),
    .mode_o(mode), .idx_o(idx_o), .idx_valid_o(idx_valid_o),
    .n_o(n_o), .m_o(m_o), .nm_valid_o(nm_valid_o)
  );

  assign mode_o = mode;

  a_r4_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
    nm_valid_o |-> (N_W'(m_o) < n_o));
  a_r2_normal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (!nm_valid_o && n_o == '0 && m_o == '0));
endmodule

// File: tb/tb_clk_src_sel.sv
module tb_clk_src_sel;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] strap_i, sw_sel_i;
  logic       override_i, prog_en_i, rcv_sel_i;
  logic       wr_pn_i, wr_pm_i, wr_rn_i, wr_rm_i, txn_end_i;
  logic [7:0] pn_i, rn_i;
  logic [6:0] pm_i, rm_i;
  logic       wd_timeout_i, wd_clr_i;
  logic [4:0] strap_o, idx_o;
  logic [1:0] mode_o;
  logic       idx_valid_o, nm_valid_o, freq_chg_o;
  logic [7:0] n_o;
  logic [6:0] m_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_sel dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .sw_sel_i(sw_sel_i),
    .override_i(override_i), .prog_en_i(prog_en_i), .rcv_sel_i(rcv_sel_i),
    .wr_pn_i(wr_pn_i), .pn_i(pn_i), .wr_pm_i(wr_pm_i), .pm_i(pm_i),
    .wr_rn_i(wr_rn_i), .rn_i(rn_i), .wr_rm_i(wr_rm_i), .rm_i(rm_i),
    .txn_end_i(txn_end_i), .wd_timeout_i(wd_timeout_i), .wd_clr_i(wd_clr_i),
    .strap_o(strap_o), .mode_o(mode_o), .idx_o(idx_o), .idx_valid_o(idx_valid_o),
    .n_o(n_o), .m_o(m_o), .nm_valid_o(nm_valid_o), .freq_chg_o(freq_chg_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rsv_ok(input int code);
    return (code >= 16 && code <= 18) ? 0 : 1;
  endfunction

  task automatic clear_strobes();
    wr_pn_i = 0; wr_pm_i = 0; wr_rn_i = 0; wr_rm_i = 0;
    txn_end_i = 0; wd_timeout_i = 0; wd_clr_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    finish_run();
  end

  initial begin
    int held;
    rst_n = 0; strap_i = 0; sw_sel_i = 0; override_i = 0; prog_en_i = 0;
    rcv_sel_i = 0; pn_i = 0; pm_i = 0; rn_i = 0; rm_i = 0;
    clear_strobes();

    // R1, R2, R5: every strap code through a reset
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      rst_n = 0; strap_i = 5'(s);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      strap_i = ~5'(s);
      @(negedge clk);
      chk("R1 strap held", int'(strap_o), s);
      chk("R2 idx from strap", int'(idx_o), s);
      chk("R2 mode normal", int'(mode_o), 0);
      chk("R2 pair unused", int'(nm_valid_o), 0);
      chk("R5 strap code validity", int'(idx_valid_o), rsv_ok(s));
      chk("R13 no event after reset", int'(freq_chg_o), 0);
    end
    held = 31;

    // R2, R5: software index sweep
    override_i = 1;
    for (int v = 0; v < 32; v++) begin
      sw_sel_i = 5'(v);
      @(negedge clk);
      chk("R2 idx from sw", int'(idx_o), v);
      chk("R5 sw code validity", int'(idx_valid_o), rsv_ok(v));
    end

    // R3, R4, R6: programmed pairs, both written in one transaction
    prog_en_i = 1; sw_sel_i = 5'd9;
    for (int mi = 0; mi < 4; mi++) begin
      int mv;
      mv = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 93 : 127;
      for (int n = 0; n < 256; n++) begin
        pn_i = 8'(n); pm_i = 7'(mv);
        wr_pn_i = 1; wr_pm_i = 1; txn_end_i = 1;
        @(negedge clk);
        clear_strobes();
        chk("R3 n_o", int'(n_o), n);
        chk("R3 m_o", int'(m_o), mv);
        chk("R3 idx by override", int'(idx_o), 9);
        chk("R3 mode prog", int'(mode_o), 1);
        chk("R4 pair legality", int'(nm_valid_o), (n + 3 > mv + 3) ? 1 : 0);
        chk("R6 event", int'(freq_chg_o), 1);
        @(negedge clk);
        chk("R8 event one cycle", int'(freq_chg_o), 0);
      end
    end

    // R8: writes spread over one transaction give one event at its end
    pn_i = 8'd150; wr_pn_i = 1;
    @(negedge clk); clear_strobes();
    chk("R8 no event before end", int'(freq_chg_o), 0);
    @(negedge clk);
    chk("R8 still none", int'(freq_chg_o), 0);
    pm_i = 7'd48; wr_pm_i = 1; txn_end_i = 1;
    @(negedge clk); clear_strobes();
    chk("R8 single event", int'(freq_chg_o), 1);
    @(negedge clk);
    chk("R8 event dropped", int'(freq_chg_o), 0);
    txn_end_i = 1;
    @(negedge clk); clear_strobes();
    chk("R13 empty transaction", int'(freq_chg_o), 0);

    // R7: recovery register writes
    rn_i = 8'd200; wr_rn_i = 1; txn_end_i = 1;
    @(negedge clk); clear_strobes();
    chk("R7 event on rcv N", int'(freq_chg_o), 1);
    rm_i = 7'd10; wr_rm_i = 1; txn_end_i = 1;
    @(negedge clk); clear_strobes();
    chk("R7 event on rcv M", int'(freq_chg_o), 1);
    chk("R3 prog pair unaffected", int'(n_o), 150);

    // R9, R12: timeout with strap recovery source
    rcv_sel_i = 0; wd_timeout_i = 1;
    @(negedge clk); clear_strobes();
    chk("R9 mode rcv strap", int'(mode_o), 2);
    chk("R9 idx strap", int'(idx_o), held);
    chk("R9 n zero", int'(n_o), 0);
    chk("R12 pair unused", int'(nm_valid_o), 0);

    // R10: recovery pair
    rcv_sel_i = 1;
    @(negedge clk);
    chk("R10 mode rcv pair", int'(mode_o), 3);
    chk("R10 n", int'(n_o), 200);
    chk("R10 m", int'(m_o), 10);
    chk("R10 idx by override", int'(idx_o), 9);
    chk("R10 legal", int'(nm_valid_o), 1);

    // R11: persists, clear+timeout keeps it, clear alone leaves
    for (int k = 0; k < 5; k++) @(negedge clk);
    chk("R11 persists", int'(mode_o), 3);
    wd_clr_i = 1; wd_timeout_i = 1;
    @(negedge clk); clear_strobes();
    chk("R11 timeout beats clear", int'(mode_o), 3);
    wd_clr_i = 1;
    @(negedge clk); clear_strobes();
    chk("R11 cleared", int'(mode_o), 1);
    chk("R11 prog pair back", int'(n_o), 150);
    prog_en_i = 0;
    @(negedge clk);
    chk("R2 normal again", int'(mode_o), 0);
    chk("R2 n zero", int'(n_o), 0);

    finish_run();
  end
endmodule